// File: doc/BRIEF.md
# Sized Logical Shift Unit

This block carries out a logical shift of a byte, word or long operand held in a data register, moving one bit position per clock. A decoded shift instruction is presented alongside a one-cycle start pulse: the direction, the operand size, a select that chooses between a small immediate count and a count taken from a register, and the operand itself. After the requested number of steps the block presents the shifted register value, the condition flags N, Z, V, C and X, and a one-cycle done strobe.

Only the low byte, word or long of the register is shifted. Bits above the selected size pass through unchanged. Zeros are shifted in at the vacated end. The last bit shifted out becomes both the carry and the extend flag. The current extend flag is an input so that a zero-length shift can return it unchanged. Operand fetch, write-back, and the arithmetic and rotate forms belong to the surrounding execution unit.

Top module: `sized_lshift`

## Requirements
- R1: A start pulse while `busy` is low captures the operand, size, direction, count and `x_in`, and `busy` is high from the next cycle until done. A start pulse while `busy` is high is ignored and does not alter the operation in flight.
- R2: With `cnt_src` = 0 the count is `cnt_imm` (1 to 7), and the field value 0 means 8. With `cnt_src` = 1 the count is `cnt_reg` modulo 64, which is its low six bits.
- R3: `done` is a single-cycle pulse that is first seen high exactly count+1 clock edges after the edge that sampled start.
- R4: With `shift_left` = 1, each step moves the sized field up one bit and enters a 0 at bit 0. The bit shifted out is the field's top bit: bit 7 for byte, bit 15 for word, bit 31 for long.
- R5: With `shift_left` = 0, each step moves the sized field down one bit and enters a 0 at the field's top bit. The bit shifted out is bit 0.
- R6: Bits of `result` above the selected size equal the same bits of the operand.
- R7: For a nonzero count, `flag_c` and `flag_x` both equal the last bit shifted out. A count larger than the field width therefore gives 0.
- R8: For a zero count, `result` equals the operand, `flag_c` is 0 and `flag_x` equals the captured `x_in`.
- R9: `flag_n` is the top bit of the sized result, `flag_z` is 1 exactly when the sized result is zero, and `flag_v` is 0.
- R10: The `size` encoding is 0 = byte, 1 = word, 2 = long, and 3 is treated as long.
- R11: `result` and the flags change only in the cycle `done` is high and hold their values otherwise. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a shift (ignored while busy) |
| shift_left | input | 1 | 1 = shift toward the MSB, 0 = toward the LSB |
| size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| cnt_src | input | 1 | 0 = immediate count field, 1 = register count |
| cnt_imm | input | 3 | Immediate count, 0 means 8 |
| cnt_reg | input | 32 | Register supplying the count (low 6 bits used) |
| operand | input | 32 | Register value to shift |
| x_in | input | 1 | Current extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Shifted register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always cleared) |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
A corrupted step counter shows at the ports on the same operation, as a done pulse that arrives early or late against the count+1 rule. It may also show as a result shifted by the wrong amount. A wrong in-field mux or size latch leaves a misplaced bit in `result` or a wrong N/Z flag when done fires. A leak across the field boundary disturbs the preserved upper bits at that same done cycle. Stale carry or extend tracking appears as wrong C or X on the first shift whose final shifted-out bit differs from the earlier state. Zero-count operations expose it directly through the X pass-through. The sweep covers every size code, both directions, every immediate field and every register count from 0 to 63. Each of these faults is therefore reported within one operation of the cycle it occurs.

// File: rtl/shift_pkg.sv
package shift_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE     = 2'b00,
      SZ_WORD     = 2'b01,
      SZ_LONG     = 2'b10,
      SZ_LONG_ALT = 2'b11
   } size_e;

   function automatic logic is_byte(size_e s);
      return s == SZ_BYTE;
   endfunction

   function automatic logic is_word(size_e s);
      return s == SZ_WORD;
   endfunction

endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel
   import shift_pkg::*;
#(
   parameter int IMM_W = 3,
   parameter int CNT_W = 6
) (
   input  logic             from_reg,
   input  logic [IMM_W-1:0] imm,
   input  logic [CNT_W-1:0] reg_low,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(2 ** IMM_W);

   logic [CNT_W-1:0] imm_ext;

   generate
      if (CNT_W > IMM_W) begin : g_ext
         assign imm_ext = {{(CNT_W-IMM_W){1'b0}}, imm};
      end else begin : g_noext
         assign imm_ext = imm[CNT_W-1:0];
      end
   endgenerate

   always_comb begin
      if (from_reg)
         count = reg_low;
      else if (imm == '0)
         count = IMM_ZERO_CNT;
      else
         count = imm_ext;
   end
endmodule

// File: rtl/shift_step.sv
module shift_step
   import shift_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] cur,
   input  size_e             sz,
   input  logic              left,
   output logic [DATA_W-1:0] nxt,
   output logic              out_bit
);
   logic top_bit;

   always_comb begin
      if (is_byte(sz))
         top_bit = cur[LANE_W-1];
      else if (is_word(sz))
         top_bit = cur[2*LANE_W-1];
      else
         top_bit = cur[DATA_W-1];
      out_bit = left ? top_bit : cur[0];
   end

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam bit IN_B  = (i < LANE_W);
         localparam bit IN_W  = (i < 2*LANE_W);
         localparam bit TOP_B = (i == LANE_W-1);
         localparam bit TOP_W = (i == 2*LANE_W-1);
         localparam bit TOP_L = (i == DATA_W-1);
         logic in_field, is_top, from_low, from_high;

         assign in_field = is_byte(sz) ? IN_B : (is_word(sz) ? IN_W : 1'b1);
         assign is_top   = is_byte(sz) ? TOP_B : (is_word(sz) ? TOP_W : TOP_L);

         if (i == 0) begin : g_lo_edge
            assign from_low = 1'b0;
         end else begin : g_lo
            assign from_low = cur[i-1];
         end

         if (i == DATA_W-1) begin : g_hi_edge
            assign from_high = 1'b0;
         end else begin : g_hi
            assign from_high = cur[i+1];
         end

         assign nxt[i] = !in_field ? cur[i] :
                         left      ? from_low :
                         is_top    ? 1'b0 : from_high;
      end
   endgenerate
endmodule

// File: rtl/shift_flags.sv
module shift_flags
   import shift_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] val,
   input  size_e             sz,
   output logic [DATA_W-1:0] field_mask,
   output logic              msb,
   output logic              zero
);
   localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
   localparam logic [DATA_W-1:0] MASK_W = {{(DATA_W-2*LANE_W){1'b0}}, {(2*LANE_W){1'b1}}};
   localparam logic [DATA_W-1:0] MASK_L = {DATA_W{1'b1}};

   always_comb begin
      if (is_byte(sz)) begin
         field_mask = MASK_B;
         msb        = val[LANE_W-1];
      end else if (is_word(sz)) begin
         field_mask = MASK_W;
         msb        = val[2*LANE_W-1];
      end else begin
         field_mask = MASK_L;
         msb        = val[DATA_W-1];
      end
      zero = (val & field_mask) == '0;
   end
endmodule

// File: rtl/sized_lshift.sv
module sized_lshift
   import shift_pkg::*;
#(
   parameter  int LANE_W = 8,
   parameter  int IMM_W  = 3,
   parameter  int CNT_W  = 6,
   localparam int DATA_W = 4 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              shift_left,
   input  logic [1:0]        size,
   input  logic              cnt_src,
   input  logic [IMM_W-1:0]  cnt_imm,
   input  logic [DATA_W-1:0] cnt_reg,
   input  logic [DATA_W-1:0] operand,
   input  logic              x_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_x
);
   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("LANE_W must be at least 2");
      end
      if (CNT_W <= IMM_W) begin : g_bad_cnt
         $error("CNT_W must exceed IMM_W so the zero-field count fits");
      end
      if (CNT_W >= DATA_W) begin : g_bad_reg
         $error("CNT_W must be narrower than the data path");
      end
   endgenerate

   logic              busy_q, done_q, left_q, last_q, xtrk_q;
   size_e             size_q;
   logic [CNT_W-1:0]  remain_q, cnt_sel;
   logic [DATA_W-1:0] work_q, step_nxt, field_mask, result_q;
   logic              step_out, f_msb, f_zero;
   logic              n_q, z_q, c_q, x_q;
   logic              unused_cnt_hi;
   logic              accept;

   assign unused_cnt_hi = ^cnt_reg[DATA_W-1:CNT_W];
   assign accept        = start && !busy_q;

   shift_count_sel #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_cnt (
      .from_reg (cnt_src),
      .imm      (cnt_imm),
      .reg_low  (cnt_reg[CNT_W-1:0]),
      .count    (cnt_sel)
   );

   shift_step #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_step (
      .cur     (work_q),
      .sz      (size_q),
      .left    (left_q),
      .nxt     (step_nxt),
      .out_bit (step_out)
   );

   shift_flags #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_flags (
      .val        (work_q),
      .sz         (size_q),
      .field_mask (field_mask),
      .msb        (f_msb),
      .zero       (f_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         left_q   <= 1'b0;
         size_q   <= SZ_BYTE;
         remain_q <= '0;
         work_q   <= '0;
         last_q   <= 1'b0;
         xtrk_q   <= 1'b0;
         result_q <= '0;
         n_q      <= 1'b0;
         z_q      <= 1'b0;
         c_q      <= 1'b0;
         x_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q   <= 1'b1;
            left_q   <= shift_left;
            size_q   <= size_e'(size);
            remain_q <= cnt_sel;
            work_q   <= operand;
            last_q   <= 1'b0;
            xtrk_q   <= x_in;
         end else if (busy_q) begin
            if (remain_q == '0) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               result_q <= work_q;
               n_q      <= f_msb;
               z_q      <= f_zero;
               c_q      <= last_q;
               x_q      <= xtrk_q;
            end else begin
               work_q   <= step_nxt;
               remain_q <= remain_q - CNT_W'(1);
               last_q   <= step_out;
               xtrk_q   <= step_out;
            end
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign result = result_q;
   assign flag_n = n_q;
   assign flag_z = z_q;
   assign flag_v = 1'b0;
   assign flag_c = c_q;
   assign flag_x = x_q;

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && remain_q != '0) |=> (busy_q && remain_q == $past(remain_q) - CNT_W'(1)));

   a_r1_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && remain_q != '0 && start) |=> ($stable(size_q) && $stable(left_q)));

   a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && remain_q != '0) |=> (((work_q ^ $past(work_q)) & ~field_mask) == '0));

   a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> ($stable(result_q) && $stable(c_q) && $stable(x_q)));

   a_r8_zero_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt_sel == '0) |=> ##1 (done_q && !c_q && result_q == $past(operand, 2)));

   a_r7_carry_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && remain_q == CNT_W'(1)) |=> ##1 (done_q && c_q == $past(step_out, 2)
                                                 && x_q == $past(step_out, 2)));
endmodule

// File: tb/sized_lshift_test.sv
module sized_lshift_test;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          shift_left = 1'b0;
   logic [1:0]    size = 2'd0;
   logic          cnt_src = 1'b0;
   logic [2:0]    cnt_imm = 3'd0;
   logic [DW-1:0] cnt_reg = '0;
   logic [DW-1:0] operand = '0;
   logic          x_in = 1'b0;
   logic          busy, done, flag_n, flag_z, flag_v, flag_c, flag_x;
   logic [DW-1:0] result;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sized_lshift uut (
      .clk(clk), .rst_n(rst_n), .start(start), .shift_left(shift_left),
      .size(size), .cnt_src(cnt_src), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg),
      .operand(operand), .x_in(x_in), .busy(busy), .done(done),
      .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
      .flag_c(flag_c), .flag_x(flag_x)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One operation: start, wait for done, compare with arithmetic model.
   task automatic run_op(input logic [DW-1:0] op, input logic [1:0] sz, input bit lft,
                         input bit src, input logic [2:0] imm, input logic [DW-1:0] rc,
                         input bit xi, input bit poke_busy);
      int n, w, lat;
      logic [63:0] mask, f, nf, exp_res;
      bit outb, exp_c, exp_x;
      // R2: count source
      n = src ? int'(rc % 64) : ((imm == 3'd0) ? 8 : int'(imm));
      // R10: size encoding
      w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      mask = (64'd1 << w) - 64'd1;
      f = {32'd0, op} & mask;
      if (n == 0) begin
         nf = f; exp_c = 1'b0; exp_x = xi;
      end else begin
         if (lft) begin
            nf   = (n >= w) ? 64'd0 : ((f << n) & mask);
            outb = (n > w) ? 1'b0 : f[w-n];
         end else begin
            nf   = (n >= w) ? 64'd0 : (f >> n);
            outb = (n > w) ? 1'b0 : f[n-1];
         end
         exp_c = outb; exp_x = outb;
      end
      exp_res = ({32'd0, op} & ~mask) | nf;

      @(negedge clk);
      operand = op; size = sz; shift_left = lft; cnt_src = src;
      cnt_imm = imm; cnt_reg = rc; x_in = xi; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         if (poke_busy && lat == 2) begin
            operand = ~op; shift_left = ~lft; size = ~sz; cnt_src = 1'b1;
            cnt_reg = 32'd1; x_in = ~xi; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      check(lat == n + 1, poke_busy ? "R1 latency with start while busy" : "R3 latency",
            64'(lat), 64'(n + 1));
      check(result == exp_res[31:0],
            (n == 0) ? "R8 result" : (poke_busy ? "R1 result" : (lft ? "R4 result" : "R5 result")),
            {32'd0, result}, exp_res);
      check(({32'd0, result} & ~mask) == ({32'd0, op} & ~mask), "R6 upper bits",
            {32'd0, result} & ~mask, {32'd0, op} & ~mask);
      check(flag_c == exp_c, (n == 0) ? "R8 carry" : "R7 carry", 64'(flag_c), 64'(exp_c));
      check(flag_x == exp_x, (n == 0) ? "R8 extend" : "R7 extend", 64'(flag_x), 64'(exp_x));
      check(flag_n == nf[w-1], "R9 negative", 64'(flag_n), 64'(nf[w-1]));
      check(flag_z == (nf == 64'd0), "R9 zero", 64'(flag_z), 64'(nf == 64'd0));
      check(flag_v == 1'b0, "R9 overflow", 64'(flag_v), 64'd0);
      @(negedge clk);
      check(done == 1'b0, "R3 done single pulse", 64'(done), 64'd0);
      check(result == exp_res[31:0], "R11 result holds", {32'd0, result}, exp_res);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] ops [4];
      ops[0] = 32'hA5C3_7E81;
      ops[1] = 32'h8000_0001;
      ops[2] = 32'hFFFF_FFFF;
      ops[3] = 32'h1234_8100;

      repeat (3) @(negedge clk);
      // R11: reset state
      check(busy == 0 && done == 0, "R11 reset busy/done", {62'd0, busy, done}, 64'd0);
      check(result == '0, "R11 reset result", {32'd0, result}, 64'd0);
      check({flag_n, flag_z, flag_v, flag_c, flag_x} == 5'd0, "R11 reset flags",
            64'({flag_n, flag_z, flag_v, flag_c, flag_x}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Immediate counts, every field value, every size code, both directions.
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 2; d++)
            for (int im = 0; im < 8; im++)
               for (int k = 0; k < 4; k++)
                  run_op(ops[k], 2'(s), d[0], 1'b0, 3'(im), 32'd0, k[0] ^ im[0], 1'b0);

      // Register counts 0..63.
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 2; d++)
            for (int rc = 0; rc < 64; rc++)
               for (int k = 0; k < 4; k += 2)
                  run_op(ops[k + (rc & 1)], 2'(s), d[0], 1'b1, 3'd5, 32'(rc),
                         rc[1], 1'b0);

      // R2: register count modulo 64 with upper bits set.
      run_op(32'hDEAD_BEEF, 2'd1, 1'b1, 1'b1, 3'd0, 32'd69, 1'b0, 1'b0);
      run_op(32'hDEAD_BEEF, 2'd2, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFC0, 1'b1, 1'b0);
      run_op(32'h0000_00F0, 2'd0, 1'b0, 1'b1, 3'd0, 32'd200, 1'b0, 1'b0);

      // R1: start during busy is ignored.
      run_op(32'h8421_0F0F, 2'd2, 1'b1, 1'b1, 3'd0, 32'd20, 1'b1, 1'b1);
      run_op(32'h0000_0081, 2'd0, 1'b0, 1'b0, 3'd6, 32'd0, 1'b0, 1'b1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule